// File: doc/BRIEF.md
# Local Timebase Prescaler

This block produces the 64-bit free-running count that the per-core timers compare against. On each cycle it takes one of two single-cycle clock enables: the crystal enable, whose nominal rate is 19.2 MHz, or an alternate enable. A control bit chooses which one. A 32-bit fractional prescaler thins the chosen enable into ticks, and on every tick the count moves forward by one or by two.

The prescaler value is a ratio against 2^31, so 0x80000000 gives one tick for every enable. Each enable adds the prescaler to a fraction accumulator. A tick fires each time the sum reaches 2^31, and 2^31 is then taken off the sum. Values above 0x80000000 act as 1:1. A value of zero stops the count.

Software uses a small register port with a combinational read path. A read of the low count word captures the high word at the same instant, so a later read of the high word forms a consistent 64-bit pair with it.

Top module: `local_timebase`

## Requirements
- R1: After reset the count is 0, `tick` is 0, the control register (word address 0) reads 0 and the prescaler register (word address 1) reads 0x80000000.
- R2: When control bit 8 is 0, only `xtal_en` advances the fraction accumulator and `alt_en` has no effect.
- R3: When control bit 8 is 1, only `alt_en` advances the fraction accumulator and `xtal_en` has no effect.
- R4: When control bit 9 is 0, each tick adds 1 to the count. When it is 1, each tick adds 2.
- R5: With prescaler 0x80000000, every selected enable produces `tick` high and an updated `count` in the cycle after the enable.
- R6: On each selected enable the prescaler is added to the fraction accumulator. When the sum reaches 2^31, a tick fires and 2^31 is subtracted from the sum. Otherwise the sum is kept.
- R7: Prescaler values above 0x80000000 behave exactly like 0x80000000. The register still reads back the written value.
- R8: A prescaler value of 0 produces no tick and leaves the count unchanged.
- R9: A read of word address 2 returns count bits 31:0. The same read captures count bits 63:32, and word address 3 returns that captured value.
- R10: Only control bits 8 and 9 are stored. All other control bits read as 0.
- R11: `tick` is high for one cycle per increment, and `count` changes only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_en | input | 1 | Crystal clock enable, one cycle per crystal period |
| alt_en | input | 1 | Alternate clock enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (captures the high word when reading word 2) |
| addr | input | 2 | Register word address: 0 control, 1 prescaler, 2 count low, 3 captured count high |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| count | output | 64 | Free-running timebase count |
| tick | output | 1 | One-cycle strobe on each count increment |

## Verification
The bench goes after the accumulator at fractional ratios. A design that dropped the remainder after a carry, or compared against the wrong threshold, would drift away from the expected tick count within a few enables. Values just above 1:1, including 0xFFFFFFFF, must not produce double ticks or wrap the accumulator. A prescaler of zero must hold the count still. The bench also drives the unselected enable while the other source is active, and a swapped source mux would count those enables. Finally it checks step-of-two counting and the masking of unused control bits on readback.

// File: rtl/lt_pkg.sv
// Shared constants for the local timebase: widths, register word
// addresses, control bit positions and the 1:1 prescaler value.
package lt_pkg;
    localparam int unsigned DW       = 32;
    localparam int unsigned CW       = 64;
    localparam int unsigned AW       = 2;
    localparam int unsigned SRC_BIT  = 8;
    localparam int unsigned STEP_BIT = 9;
    localparam logic [DW-1:0] UNITY  = 32'h8000_0000;

    localparam logic [AW-1:0] A_CTRL   = 2'd0;
    localparam logic [AW-1:0] A_PRESC  = 2'd1;
    localparam logic [AW-1:0] A_CNT_LO = 2'd2;
    localparam logic [AW-1:0] A_CNT_HI = 2'd3;
endpackage

// File: rtl/lt_regs.sv
// Register file of the timebase. Holds the source and step bits and the
// prescaler, and captures the high count word when the low word is read.
// Assumes single-cycle write and read strobes; the read path is combinational.
module lt_regs
    import lt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] count,
    output logic [DW-1:0] rdata,
    output logic          src_alt,
    output logic          step_two,
    output logic [DW-1:0] presc,
    output logic [DW-1:0] hi_hold
);
    localparam int unsigned HW = CW - DW;

    // Control and prescaler registers, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_alt  <= 1'b0;
            step_two <= 1'b0;
            presc    <= UNITY;
        end else if (wr_en) begin
            if (addr == A_CTRL) begin
                src_alt  <= wdata[SRC_BIT];
                step_two <= wdata[STEP_BIT];
            end
            if (addr == A_PRESC) begin
                presc <= wdata;
            end
        end
    end

    // Capture the high count word whenever the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_hold <= '0;
        end else if (rd_en && addr == A_CNT_LO) begin
            hi_hold <= count[CW-1:CW-HW];
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[SRC_BIT]  = src_alt;
                rdata[STEP_BIT] = step_two;
            end
            A_PRESC:  rdata = presc;
            A_CNT_LO: rdata = count[DW-1:0];
            A_CNT_HI: rdata = hi_hold;
        endcase
    end
endmodule

// File: rtl/lt_prescale.sv
// Source selection and fractional accumulation. Each selected enable adds
// the clamped prescaler to a fraction held below 2^31. A sum at or above
// 2^31 raises 'fire' in the same cycle and keeps the remainder.
// Assumes enables are single-cycle pulses in the clk domain.
module lt_prescale
    import lt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xtal_en,
    input  logic          alt_en,
    input  logic          src_alt,
    input  logic [DW-1:0] presc,
    output logic          fire
);
    logic          src_en;
    logic [DW-1:0] p_eff;
    logic [DW:0]   sum;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] acc_d;

    // Pick the enable, clamp the ratio and form the next fraction.
    always_comb begin
        src_en = src_alt ? alt_en : xtal_en;
        p_eff  = (presc > UNITY) ? UNITY : presc;
        sum    = {1'b0, acc_q} + {1'b0, p_eff};
        fire   = src_en && (sum >= {1'b0, UNITY});
        if (!src_en)
            acc_d = acc_q;
        else if (fire)
            acc_d = sum[DW-1:0] - UNITY;
        else
            acc_d = sum[DW-1:0];
    end

    // Fraction accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/lt_counter.sv
// The 64-bit count and its tick strobe. Adds one or two on each fire,
// with the tick strobe registered alongside the count.
module lt_counter
    import lt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          step_two,
    output logic [CW-1:0] count,
    output logic          tick
);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    // Advance the count and pulse the strobe on each fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= fire;
            if (fire) count <= count + (step_two ? TWO : ONE);
        end
    end
endmodule

// File: rtl/local_timebase.sv
// Top of the local timebase: register file, prescaler and counter.
// Assumes one clock domain, with both source enables already synchronised.
module local_timebase
    import lt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xtal_en,
    input  logic          alt_en,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic [63:0]   count,
    output logic          tick
);
    logic          src_alt;
    logic          step_two;
    logic [DW-1:0] presc;
    logic [DW-1:0] hi_hold;
    logic          fire;

    lt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .count(count), .rdata(rdata),
        .src_alt(src_alt), .step_two(step_two), .presc(presc),
        .hi_hold(hi_hold)
    );

    lt_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .alt_en(alt_en),
        .src_alt(src_alt), .presc(presc), .fire(fire)
    );

    lt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .fire(fire), .step_two(step_two),
        .count(count), .tick(tick)
    );
endmodule

// File: rtl/lt_chk.sv
// Assertion checker for local_timebase, attached by bind.
module lt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xtal_en,
    input logic        alt_en,
    input logic        rd_en,
    input logic [1:0]  addr,
    input logic        src_alt,
    input logic        step_two,
    input logic [31:0] presc,
    input logic [31:0] hi_hold,
    input logic [63:0] count,
    input logic        tick
);
    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> count == $past(count));
    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> count == $past(count) + ($past(step_two) ? 64'd2 : 64'd1));
    // R8
    zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc == 32'd0 |=> !tick);
    // R2
    xtal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_alt && !xtal_en) |=> !tick);
    // R3
    alt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_alt && !alt_en) |=> !tick);
    // R9
    hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd2) |=> hi_hold == $past(count[63:32]));
endmodule

bind local_timebase lt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .alt_en(alt_en),
    .rd_en(rd_en), .addr(addr), .src_alt(src_alt), .step_two(step_two),
    .presc(presc), .hi_hold(hi_hold), .count(count), .tick(tick)
);

// File: tb/tb_local_timebase.sv
module tb_local_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b0, alt_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] count;
    logic        tick;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [63:0] m_cnt = '0;
    logic [31:0] m_acc = '0, m_ctrl = '0, m_presc = 32'h8000_0000, m_hi = '0;
    logic        m_tick = 1'b0;

    local_timebase dut (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] eff(input logic [31:0] p);
        return (p > 32'h8000_0000) ? 32'h8000_0000 : p;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model of one clock edge, from the requirements (R2..R8, R11).
    task automatic model_step(input logic xe, input logic ae);
        logic        en;
        logic [32:0] s;
        en = m_ctrl[8] ? ae : xe;
        m_tick = 1'b0;
        if (en) begin
            s = {1'b0, m_acc} + {1'b0, eff(m_presc)};
            if (s >= 33'h0_8000_0000) begin
                m_tick = 1'b1;
                m_acc  = s[31:0] - 32'h8000_0000;
                m_cnt  = m_cnt + (m_ctrl[9] ? 64'd2 : 64'd1);
            end else begin
                m_acc = s[31:0];
            end
        end
    endtask

    task automatic compare(input string req);
        check({req, " tick"}, {63'd0, tick}, {63'd0, m_tick});
        check({req, " count"}, count, m_cnt);
    endtask

    task automatic cyc(input logic xe, input logic ae, input string req);
        xtal_en = xe; alt_en = ae;
        @(posedge clk);
        model_step(xe, ae);
        #1;
        xtal_en = 1'b0; alt_en = 1'b0;
        compare(req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        model_step(1'b0, 1'b0);
        if (a == 2'd0) m_ctrl = d & 32'h0000_0300;
        if (a == 2'd1) m_presc = d;
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, {32'd0, rdata}, {32'd0, exp});
        @(posedge clk);
        if (a == 2'd2) m_hi = m_cnt[63:32];
        model_step(1'b0, 1'b0);
        #1;
        rd_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 count", count, 64'd0);
        check("R1 tick", {63'd0, tick}, 64'd0);
        rd(2'd0, 32'd0, "R1 ctrl");
        rd(2'd1, 32'h8000_0000, "R1 presc");
        // R5 1:1 ticks on every enable
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R5");
        // R2 alt ignored when crystal selected
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R2");
        // R4 step of two
        wr(2'd0, 32'h0000_0200);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R4");
        // R3 alternate source; crystal ignored
        wr(2'd0, 32'h0000_0100);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R3");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R3");
        // R10 unused control bits masked
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h0000_0300, "R10");
        wr(2'd0, 32'h0);
        // R7 clamp above 1:1
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 32'hFFFF_FFFF, "R7 readback");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, "R7");
        wr(2'd1, 32'h8000_0001);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, "R7");
        // R8 zero stops
        wr(2'd1, 32'h0);
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, "R8");
        // R6 quarter and odd ratios
        wr(2'd1, 32'h2000_0000);
        for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, "R6");
        wr(2'd1, 32'h5555_5555);
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, "R6");
        // R9 low read then captured high
        rd(2'd2, m_cnt[31:0], "R9 low");
        rd(2'd3, m_hi, "R9 high");
        // Random mix (R6 general ratio tracking, R11 strobe/count)
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom % 100;
            if (r < 3)       wr(2'd0, $urandom);
            else if (r < 6)  wr(2'd1, ($urandom % 4 == 0) ? $urandom : ($urandom >> 1));
            else if (r < 8)  rd(2'd2, m_cnt[31:0], "R9 random low");
            else             cyc(1'($urandom), 1'($urandom), "R6 R11 random");
        end
        rd(2'd3, m_hi, "R9 final high");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule